// File: doc/BRIEF.md
# Complementary PWM Pair with Current-Direction Duty Correction

This block drives one top/bottom pair of motor-bridge gate signals from a single up/down (center-aligned) counter. Software loads two duty values. In complementary mode a current-direction flag picks one of them for each PWM period. The usual use is to offset the voltage error that deadtime causes: the duty is raised or lowered depending on which way the phase current flows. The direction comes from one of two sources, chosen by a sense-mode input. The first source is an external sense pin, sampled at a period start. The second is a software direction bit.

The block buffers the direction flag and both duty values at every period start, so each period is governed by exactly one duty value. The sense-mode input is used live. A programmable deadtime delays each turn-on in complementary mode. An output polarity bit for each side is applied after the deadtime stage. The two polarity bits sit in a configuration register that keeps only its first write after reset. An independent mode drives the two outputs from their own duty values and inserts no deadtime.

Top module: `cpwm_pair`

## Requirements
- R1: After reset both outputs are low. Both duty registers are 0, the modulus register holds MOD_RST, the deadtime register is 0, and both polarity bits are 0 (positive).
- R2: While enabled, the counter counts 0,1,…,M and then M-1,…,1, where M is the modulus (register address 2). A period therefore lasts 2M cycles. In complementary mode the top side is active while the counter is below the selected duty D, so with steady settings and 1≤D≤M each top active run lasts 2D-1 cycles and each bottom run lasts 2M-2D+1 cycles.
- R3: In complementary mode every turn-on is delayed by the deadtime T (register address 3, low DT_W bits). Each active run is therefore shortened by T, a run shorter than T+1 never appears, and the two sides are never active in the same cycle.
- R4: Sense-mode codes: 0 or 3 means no correction (the positive duty register is used), 1 means the software direction bit, 2 means the sense pin. A direction value of 0 (positive current) selects the positive duty register (address 0); a value of 1 (negative) selects the negative duty register (address 1).
- R5: The software direction bit, the sensed pin value and both duty registers are captured only at a period start. A change made during a period first takes effect at the next period start.
- R6: The sense-mode input is not buffered. A change to it alters the duty selection within the current period.
- R7: On the first period after enable, the sensed pin direction reads positive, so the positive duty register is used even if the pin shows negative current. The pin is first captured at the end of that period.
- R8: Configuration register (address 4): bit 0 inverts the top output and bit 1 inverts the bottom output. Polarity 1 means the output is low while active; polarity 0 means it is high while active.
- R9: The configuration register accepts only its first write after reset. Later writes leave both polarity bits unchanged.
- R10: When the enable input is low, both outputs go to their inactive level on the next clock and the counter is held at 0. The next enable starts a fresh period at count 0.
- R11: In independent mode (comp_mode=0) the top side uses the positive duty register and the bottom side uses the negative one, each active while the counter is below its own value (2D-1 cycle runs). No deadtime is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_en | input | 1 | Enables the counter and the outputs |
| comp_mode | input | 1 | 1: complementary pair, 0: independent outputs |
| sense_mode | input | 2 | Direction source select (unbuffered) |
| sw_dir_neg | input | 1 | Software current direction, 1 = negative |
| cur_sense_neg | input | 1 | Sense pin, 1 = negative current (synchronous to clk) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| top_out | output | 1 | Top gate output after polarity |
| bot_out | output | 1 | Bottom gate output after polarity |

## Verification
Two of this block's functions can act in the same cycle. One is the buffered capture of the direction flag and duty values at a period boundary. The other is a live change to the sense mode, or a software change to the direction bit or a duty register, made partway through a period. The bench provokes this by changing the input just after a top run ends, while the counter is still rising. It then judges the next top run, which joins the falling half of the current period to the rising half of the next. Its length shows which duty value governed each half: the old value for buffered inputs, the new value for the sense mode.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the complementary PWM pair: register addresses and
// the direction-source select. Assumes a 3-bit register address bus.
package cpwm_pkg;

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'd0,
        SENSE_SW   = 2'd1,
        SENSE_PIN  = 2'd2,
        SENSE_OFF2 = 2'd3
    } sense_e;

    localparam logic [2:0] ADDR_DUTY_POS = 3'd0;
    localparam logic [2:0] ADDR_DUTY_NEG = 3'd1;
    localparam logic [2:0] ADDR_MODULUS  = 3'd2;
    localparam logic [2:0] ADDR_DEAD     = 3'd3;
    localparam logic [2:0] ADDR_CONFIG   = 3'd4;

endpackage

// File: rtl/cpwm_regs.sv
`timescale 1ns/1ps
// Software-visible register file: two duty values, modulus, deadtime and a
// configuration word that keeps only its first write after reset.
// Assumes single-cycle write strobes; unknown addresses are ignored.
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 4,
    parameter int MOD_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] duty_pos,
    output logic [CNT_W-1:0] duty_neg,
    output logic [CNT_W-1:0] modulus,
    output logic [DT_W-1:0]  deadtime,
    output logic             top_neg,
    output logic             bot_neg,
    output logic             cfg_locked
);

    localparam logic [CNT_W-1:0] MOD_INIT = CNT_W'(MOD_RST);

    // Register writes; configuration locks after its first write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_pos   <= '0;
            duty_neg   <= '0;
            modulus    <= MOD_INIT;
            deadtime   <= '0;
            top_neg    <= 1'b0;
            bot_neg    <= 1'b0;
            cfg_locked <= 1'b0;
        end else if (we) begin
            case (addr)
                ADDR_DUTY_POS: duty_pos <= wdata;
                ADDR_DUTY_NEG: duty_neg <= wdata;
                ADDR_MODULUS:  modulus  <= wdata;
                ADDR_DEAD:     deadtime <= wdata[DT_W-1:0];
                ADDR_CONFIG: begin
                    if (!cfg_locked) begin
                        top_neg    <= wdata[0];
                        bot_neg    <= wdata[1];
                        cfg_locked <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
// Center-aligned up/down counter. Counts 0..M then M-1..1 and flags the
// period boundary (first enabled cycle, or count 1 while falling).
// Assumes the modulus may change at any time; a lower value turns the
// count around at once.
module cpwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] modulus,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             boundary
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W:0]   INC_ONE = {{CNT_W{1'b0}}, 1'b1};

    logic           up;
    logic [CNT_W:0] cnt_inc;

    // Period start detection.
    assign boundary = en && (!running || (!up && cnt == CNT_ONE));
    assign cnt_inc  = {1'b0, cnt} + INC_ONE;

    // Counter, direction and running flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            up      <= 1'b1;
            running <= 1'b0;
        end else if (boundary) begin
            cnt     <= '0;
            up      <= 1'b1;
            running <= 1'b1;
        end else if (up) begin
            cnt <= cnt_inc[CNT_W-1:0];
            if (cnt_inc >= {1'b0, modulus}) up <= 1'b0;
        end else begin
            cnt <= cnt - CNT_ONE;
        end
    end

endmodule

// File: rtl/cpwm_select.sv
`timescale 1ns/1ps
// Period-buffered duty and direction capture plus the duty compare.
// The sense-mode select is applied live. The sensed pin is captured only
// at boundaries after the first one, so the first period reads positive.
// Assumes cur_sense pin is already synchronous to clk.
module cpwm_select
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             running,
    input  logic             boundary,
    input  logic             comp_mode,
    input  logic [1:0]       sense_mode,
    input  logic             sw_dir_neg,
    input  logic             pin_neg,
    input  logic [CNT_W-1:0] duty_pos,
    input  logic [CNT_W-1:0] duty_neg,
    input  logic [CNT_W-1:0] cnt,
    output logic             top_req,
    output logic             bot_req,
    output logic             sw_q,
    output logic             pin_q,
    output logic [CNT_W-1:0] pos_buf,
    output logic [CNT_W-1:0] neg_buf
);

    logic             use_neg;
    logic [CNT_W-1:0] duty_sel;
    logic             top_cmp;
    logic             bot_cmp;

    // Boundary capture of duties and direction sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_buf <= '0;
            neg_buf <= '0;
            sw_q    <= 1'b0;
            pin_q   <= 1'b0;
        end else if (!en) begin
            pin_q <= 1'b0;
        end else if (boundary) begin
            pos_buf <= duty_pos;
            neg_buf <= duty_neg;
            sw_q    <= sw_dir_neg;
            if (running) pin_q <= pin_neg;
        end
    end

    // Live direction-source select.
    always_comb begin
        case (sense_e'(sense_mode))
            SENSE_SW:  use_neg = sw_q;
            SENSE_PIN: use_neg = pin_q;
            default:   use_neg = 1'b0;
        endcase
    end

    // Duty compare and per-side request.
    assign duty_sel = use_neg ? neg_buf : pos_buf;
    assign top_cmp  = cnt < (comp_mode ? duty_sel : pos_buf);
    assign bot_cmp  = cnt < neg_buf;
    assign top_req  = running && top_cmp;
    assign bot_req  = running && (comp_mode ? !top_cmp : bot_cmp);

endmodule

// File: rtl/cpwm_deadtime.sv
`timescale 1ns/1ps
// Turn-on delay for one side: the active flag rises only after the request
// has been high for more than `dead` cycles and falls with the request.
// Assumes the request is glitch-free (a registered-counter compare).
module cpwm_deadtime #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            req,
    input  logic [DT_W-1:0] dead,
    output logic            act
);

    localparam logic [DT_W-1:0] DT_ONE = {{(DT_W-1){1'b0}}, 1'b1};

    logic [DT_W-1:0] dly;

    // Delay counter and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !req) begin
            dly <= '0;
            act <= 1'b0;
        end else if (dly < dead) begin
            dly <= dly + DT_ONE;
            act <= 1'b0;
        end else begin
            act <= 1'b1;
        end
    end

endmodule

// File: rtl/cpwm_pair.sv
`timescale 1ns/1ps
// Complementary PWM pair with current-direction duty correction.
// Registers, timebase, duty selection, two deadtime stages, then polarity.
// Assumes all inputs are synchronous to clk.
module cpwm_pair
    import cpwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 4,
    parameter int MOD_RST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_en,
    input  logic             comp_mode,
    input  logic [1:0]       sense_mode,
    input  logic             sw_dir_neg,
    input  logic             cur_sense_neg,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic             top_out,
    output logic             bot_out
);

    localparam int SIDES = 2;

    logic [CNT_W-1:0] duty_pos, duty_neg, modulus, cnt, pos_buf, neg_buf;
    logic [DT_W-1:0]  deadtime, dead_eff;
    logic             top_neg, bot_neg, cfg_locked;
    logic             running, boundary, sw_q, pin_q;
    logic [SIDES-1:0] req_vec, act_vec, neg_vec;

    cpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .MOD_RST(MOD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .duty_pos(duty_pos), .duty_neg(duty_neg), .modulus(modulus),
        .deadtime(deadtime), .top_neg(top_neg), .bot_neg(bot_neg),
        .cfg_locked(cfg_locked)
    );

    cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .modulus(modulus),
        .cnt(cnt), .running(running), .boundary(boundary)
    );

    cpwm_select #(.CNT_W(CNT_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .running(running),
        .boundary(boundary), .comp_mode(comp_mode), .sense_mode(sense_mode),
        .sw_dir_neg(sw_dir_neg), .pin_neg(cur_sense_neg),
        .duty_pos(duty_pos), .duty_neg(duty_neg), .cnt(cnt),
        .top_req(req_vec[0]), .bot_req(req_vec[1]),
        .sw_q(sw_q), .pin_q(pin_q), .pos_buf(pos_buf), .neg_buf(neg_buf)
    );

    // Deadtime only applies to a complementary pair.
    assign dead_eff = comp_mode ? deadtime : '0;

    generate
        for (genvar i = 0; i < SIDES; i++) begin : g_side
            cpwm_deadtime #(.DT_W(DT_W)) u_dt (
                .clk(clk), .rst_n(rst_n), .en(pwm_en), .req(req_vec[i]),
                .dead(dead_eff), .act(act_vec[i])
            );
        end
    endgenerate

    // Polarity stage after deadtime.
    assign neg_vec = {bot_neg, top_neg};
    assign top_out = act_vec[0] ^ neg_vec[0];
    assign bot_out = act_vec[1] ^ neg_vec[1];

endmodule

// File: rtl/cpwm_pair_chk.sv
`timescale 1ns/1ps
// Property checker for cpwm_pair, attached by bind below.
module cpwm_pair_chk #(
    parameter int CNT_W = 8,
    parameter int DT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_en,
    input logic             comp_mode,
    input logic             running,
    input logic             boundary,
    input logic             sw_q,
    input logic             pin_q,
    input logic             cfg_locked,
    input logic             top_neg,
    input logic             bot_neg,
    input logic             top_act,
    input logic             bot_act,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] pos_buf,
    input logic [CNT_W-1:0] neg_buf,
    input logic [DT_W-1:0]  deadtime
);

    localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(comp_mode) |-> !(top_act && bot_act));

    a_r3_gap_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(comp_mode) && $past(deadtime) != '0 && $fell(top_act)) |-> !bot_act);

    a_r3_gap_bot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(comp_mode) && $past(deadtime) != '0 && $fell(bot_act)) |-> !top_act);

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> (!top_act && !bot_act && !running && cnt == '0));

    a_r9_cfg_once: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> ($stable(top_neg) && $stable(bot_neg) && cfg_locked));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !boundary) |=> ($stable(sw_q) && $stable(pin_q)
                                   && $stable(pos_buf) && $stable(neg_buf)));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && running && !boundary) |=>
            (cnt == $past(cnt) + C_ONE || cnt == $past(cnt) - C_ONE));

    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (cnt == '0 && running));

    a_r7_first_positive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> !pin_q);

endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .comp_mode(comp_mode),
    .running(running), .boundary(boundary), .sw_q(sw_q), .pin_q(pin_q),
    .cfg_locked(cfg_locked), .top_neg(top_neg), .bot_neg(bot_neg),
    .top_act(act_vec[0]), .bot_act(act_vec[1]), .cnt(cnt),
    .pos_buf(pos_buf), .neg_buf(neg_buf), .deadtime(deadtime)
);

// File: tb/cpwm_pair_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected active-run lengths, the monitor
// measures runs on the outputs and compares them.
module cpwm_pair_test;

    localparam int CNT_W = 8;
    localparam int DT_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_en = 1'b0;
    logic comp_mode = 1'b0;
    logic [1:0] sense_mode = 2'd0;
    logic sw_dir_neg = 1'b0;
    logic cur_sense_neg = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic top_out, bot_out;

    int n_chk = 0;
    int n_bad = 0;
    bit pol_top = 1'b0;
    bit pol_bot = 1'b0;
    bit done = 1'b0;
    int q_top[$];
    string r_top[$];
    int q_bot[$];
    string r_bot[$];
    int run_top = 0;
    int run_bot = 0;
    int overlap = 0;
    int e_m;
    string r_m;

    cpwm_pair #(.CNT_W(CNT_W), .DT_W(DT_W), .MOD_RST(16)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .comp_mode(comp_mode),
        .sense_mode(sense_mode), .sw_dir_neg(sw_dir_neg),
        .cur_sense_neg(cur_sense_neg), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .top_out(top_out), .bot_out(bot_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measure active runs and compare against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (comp_mode && (top_out ^ pol_top) && (bot_out ^ pol_bot)) overlap++;
            if (top_out ^ pol_top) run_top++;
            else begin
                if (run_top > 0 && q_top.size() > 0) begin
                    e_m = q_top.pop_front();
                    r_m = r_top.pop_front();
                    check(run_top == e_m, r_m, run_top, e_m);
                end
                run_top = 0;
            end
            if (bot_out ^ pol_bot) run_bot++;
            else begin
                if (run_bot > 0 && q_bot.size() > 0) begin
                    e_m = q_bot.pop_front();
                    r_m = r_bot.pop_front();
                    check(run_bot == e_m, r_m, run_bot, e_m);
                end
                run_bot = 0;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d[CNT_W-1:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic fall_top();
        bit prev = 1'b0;
        bit cur;
        forever begin
            @(negedge clk);
            cur = top_out ^ pol_top;
            if (prev && !cur) break;
            prev = cur;
        end
        @(negedge clk);
    endtask

    task automatic fall_bot();
        bit prev = 1'b0;
        bit cur;
        forever begin
            @(negedge clk);
            cur = bot_out ^ pol_bot;
            if (prev && !cur) break;
            prev = cur;
        end
        @(negedge clk);
    endtask

    task automatic push_top(input int n, input string r);
        q_top.push_back(n);
        r_top.push_back(r);
    endtask

    task automatic push_bot(input int n, input string r);
        q_bot.push_back(n);
        r_bot.push_back(r);
    endtask

    task automatic drain();
        while (q_top.size() > 0 || q_bot.size() > 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    // Driver.
    initial begin
        int act_cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(top_out == 1'b0, "R1 top idle", int'(top_out), 0);
        check(bot_out == 1'b0, "R1 bot idle", int'(bot_out), 0);

        // R2: complementary, no correction, M=16, D=5
        wr(3'd0, 5);
        wr(3'd1, 9);
        comp_mode = 1'b1;
        sense_mode = 2'd0;
        @(negedge clk);
        pwm_en = 1'b1;
        fall_top(); fall_top();
        push_top(9, "R2 top run"); push_top(9, "R2 top run"); push_top(9, "R2 top run");
        fall_bot(); fall_bot();
        push_bot(23, "R2 bot run"); push_bot(23, "R2 bot run");
        drain();

        // R4: software direction negative selects duty 9
        sense_mode = 2'd1;
        sw_dir_neg = 1'b1;
        fall_top(); fall_top();
        push_top(17, "R4 neg reg"); push_top(17, "R4 neg reg");
        drain();

        // R5: direction bit change mid-period waits for next boundary
        fall_top();
        sw_dir_neg = 1'b0;
        push_top(13, "R5 dir buffered"); push_top(9, "R5 dir buffered");
        drain();
        // R5: duty register write mid-period waits for next boundary
        fall_top();
        wr(3'd0, 7);
        push_top(11, "R5 duty buffered"); push_top(13, "R5 duty buffered");
        drain();

        // R6: sense-mode change applies within the period
        fall_top();
        sw_dir_neg = 1'b1;
        fall_top();
        sense_mode = 2'd0;
        push_top(13, "R6 mode live"); push_top(13, "R6 mode live");
        drain();

        // R3: deadtime 3 shortens runs
        wr(3'd3, 3);
        fall_top(); fall_top();
        push_top(10, "R3 top dead"); push_top(10, "R3 top dead");
        fall_bot(); fall_bot();
        push_bot(16, "R3 bot dead"); push_bot(16, "R3 bot dead");
        drain();
        // R3: run shorter than deadtime never appears
        wr(3'd0, 1);
        fall_bot(); fall_bot();
        act_cnt = 0;
        repeat (64) begin
            @(negedge clk);
            if (top_out ^ pol_top) act_cnt++;
        end
        check(act_cnt == 0, "R3 short run suppressed", act_cnt, 0);
        fall_bot();
        push_bot(28, "R3 bot long run");
        drain();

        // R10: disable forces inactive level next clock
        @(negedge clk);
        pwm_en = 1'b0;
        @(negedge clk);
        check(top_out == 1'b0, "R10 top off", int'(top_out), 0);
        check(bot_out == 1'b0, "R10 bot off", int'(bot_out), 0);
        repeat (10) @(negedge clk);
        check(top_out == 1'b0 && bot_out == 1'b0, "R10 held off",
              int'({bot_out, top_out}), 0);

        // R7: first period after enable ignores the pin
        wr(3'd3, 0);
        wr(3'd0, 5);
        wr(3'd1, 9);
        sense_mode = 2'd2;
        cur_sense_neg = 1'b1;
        push_top(5, "R7 first period");
        push_top(13, "R7 pin captured");
        push_top(17, "R7 pin negative");
        @(negedge clk);
        pwm_en = 1'b1;
        drain();
        @(negedge clk);
        pwm_en = 1'b0;

        // R11: independent mode, no deadtime
        comp_mode = 1'b0;
        sense_mode = 2'd0;
        wr(3'd3, 3);
        @(negedge clk);
        pwm_en = 1'b1;
        fall_top(); fall_top();
        push_top(9, "R11 top indep"); push_top(9, "R11 top indep");
        fall_bot(); fall_bot();
        push_bot(17, "R11 bot indep");
        drain();
        @(negedge clk);
        pwm_en = 1'b0;

        // R8 / R9: polarity and write-once configuration
        wr(3'd4, 1);
        repeat (2) @(negedge clk);
        check(top_out == 1'b1, "R8 top idle high", int'(top_out), 1);
        check(bot_out == 1'b0, "R8 bot idle low", int'(bot_out), 0);
        wr(3'd4, 2);
        repeat (2) @(negedge clk);
        check(top_out == 1'b1, "R9 top unchanged", int'(top_out), 1);
        check(bot_out == 1'b0, "R9 bot unchanged", int'(bot_out), 0);
        pol_top = 1'b1;
        comp_mode = 1'b1;
        wr(3'd3, 0);
        @(negedge clk);
        pwm_en = 1'b1;
        fall_top(); fall_top();
        push_top(9, "R8 active-low run");
        fall_bot(); fall_bot();
        push_bot(23, "R8 bot positive run");
        drain();

        check(overlap == 0, "R3 no overlap", overlap, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule